// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits on the synchronous side of a chip and runs a 16-bit asynchronous static RAM with 17 address bits. The RAM has a pair of chip selects (one active low, one active high), an active-low read-drive enable, an active-low write strobe and an active-low select per byte lane. A single-word request port takes a direction, an address, write data and a byte mask. Each request becomes a pin sequence whose phases are whole numbers of system clocks. Those clock counts come from nanosecond parameters and the clock period when the block is elaborated.

The request port follows a valid/ready rule with back-pressure. The requester raises `req_valid` with its payload and keeps both unchanged until it sees `req_ready` high at a clock edge. `req_ready` is the completion pulse. For a read, `rsp_rdata` is valid in the same cycle. The data bus is split into a driven value, a drive enable and a sampled input, so the pad ring can build the tristate.

A write holds the selects and byte lanes steady while the write strobe sets the timing. The block keeps the write data on the bus until the strobe has risen. It also puts an all-inactive cycle between a read and a following write, so the RAM and the block never drive the bus at the same time.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is asserted, every RAM control pin is inactive: `mem_sel_n`=1, `mem_sel`=0, `mem_rd_n`=1, `mem_wr_n`=1, `mem_lane_n`=2'b11. `mem_dq_oe` and `req_ready` are 0.
- R2: Both selects are active only during a RAM cycle. The byte-lane pins stay constant from the first cycle of a RAM cycle to its last. The write strobe is never low while the selects are inactive.
- R3: A read drives `mem_rd_n` low and keeps `mem_wr_n` high. Mask bit 0 selects `mem_lane_n[0]` and data bits 7:0; mask bit 1 selects `mem_lane_n[1]` and bits 15:8. `rsp_rdata` is registered from `mem_dq_in` at the end of the access count.
- R4: `mem_rd_n` stays low for N_RD = max(1, ceil(T_ACCESS_NS/CLK_PERIOD_NS), ceil(T_RD_CYCLE_NS/CLK_PERIOD_NS)-2) cycles, which is 7 by default. `req_ready` for a read comes N_RD+1 cycles after acceptance.
- R5: A write has three phases. First, N_SETUP = max(1, ceil(address setup)) cycles with selects and lanes active and the strobe high. Second, the strobe is low for N_PULSE cycles, where N_PULSE is the largest of the strobe width, the data setup, the address-to-end time less N_SETUP and the write cycle less N_SETUP and N_HOLD. Third, N_HOLD cycles follow. By default the phases are 1, 5 and 1 cycles, and `req_ready` comes 7 cycles after acceptance.
- R6: `mem_dq_oe` is high only while `mem_wr_n` is low and `mem_rd_n` is high. The write data stays driven up to the edge where the strobe rises. `mem_rd_n` stays high through a write.
- R7: A byte-masked write changes only the lanes whose mask bit is 1. No write strobe is issued with both lane pins high.
- R8: A read with a partial mask returns zero in the unselected lane of `rsp_rdata`.
- R9: `req_ready` is high for exactly one clock per request and never for two cycles in a row.
- R10: A request with an all-zero mask gets `req_ready` in the next cycle, starts no RAM cycle and leaves the RAM contents unchanged.
- R11: A write that follows a read is preceded by one extra cycle with all pins inactive. Counted from the last cycle with `mem_rd_n` low to the first cycle with the strobe low, four cycles pass with the strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane enables, bit 0 = low byte |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| mem_addr | output | 17 | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_n | output | 1 | Active-low RAM output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_lane_n | output | 2 | Active-low byte-lane selects |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data sampled from the RAM |

## Verification
The bench builds the block with its defaults: an 8 ns clock and the faster speed grade. Neither 55/8 nor 45/8 is an integer, so the rounding up to whole cycles shows in the counts. The zero-nanosecond address setup and hold test the one-cycle minimum for setup and hold. The 5-cycle strobe comes out where the strobe-width and address-to-end limits meet. The RAM model in the bench returns garbage until the read enable has been low for six edges, so a capture made one cycle too early is visible at the ports.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_DONE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } ctl_state_e;

  // Round a nanosecond figure up to whole clock periods.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= init;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(init)));

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         capture,
  input  logic         lane_sel,
  input  logic [W-1:0] wdata_in,
  input  logic [W-1:0] dq_in,
  output logic [W-1:0] dq_out,
  output logic [W-1:0] rdata_out
);

  logic [W-1:0] wbyte_q;
  logic [W-1:0] rbyte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbyte_q <= '0;
      rbyte_q <= '0;
    end else begin
      if (load)    wbyte_q <= wdata_in;
      if (capture) rbyte_q <= lane_sel ? dq_in : '0;
    end
  end

  assign dq_out    = wbyte_q;
  assign rdata_out = rbyte_q;

  // R8
  unsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(capture) && !lane_sel) |-> (rdata_out == '0));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int CNT_W   = 3,
  parameter int N_RD    = 7,
  parameter int N_SETUP = 1,
  parameter int N_PULSE = 5,
  parameter int N_HOLD  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_init,
  output logic             accept,
  output logic             capture,
  output logic             req_ready,
  output logic             cyc_act,
  output logic             rd_act,
  output logic             wr_act
);

  localparam logic [CNT_W-1:0] INIT_RD    = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] INIT_SETUP = CNT_W'(N_SETUP - 1);
  localparam logic [CNT_W-1:0] INIT_PULSE = CNT_W'(N_PULSE - 1);
  localparam logic [CNT_W-1:0] INIT_HOLD  = CNT_W'(N_HOLD - 1);

  ctl_state_e state_q, state_d;
  logic       skip_q;
  logic       last_rd_q;
  logic       wr_end;

  assign accept  = (state_q == ST_IDLE) && req_valid && !skip_q;
  assign capture = (state_q == ST_RD_ACCESS) && tmr_expired;
  assign wr_end  = (state_q == ST_WR_HOLD) && tmr_expired;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_init = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept && (req_mask != '0)) begin
          if (req_write) begin
            if (last_rd_q) begin
              state_d = ST_TURN;
            end else begin
              state_d  = ST_WR_SETUP;
              tmr_load = 1'b1;
              tmr_init = INIT_SETUP;
            end
          end else begin
            state_d  = ST_RD_ACCESS;
            tmr_load = 1'b1;
            tmr_init = INIT_RD;
          end
        end
      end
      ST_TURN: begin
        state_d  = ST_WR_SETUP;
        tmr_load = 1'b1;
        tmr_init = INIT_SETUP;
      end
      ST_WR_SETUP: begin
        if (tmr_expired) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_init = INIT_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (tmr_expired) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_init = INIT_HOLD;
        end
      end
      ST_WR_HOLD:   if (tmr_expired) state_d = ST_IDLE;
      ST_RD_ACCESS: if (tmr_expired) state_d = ST_RD_DONE;
      ST_RD_DONE:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      skip_q    <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      skip_q  <= accept && (req_mask == '0);
      if (capture)     last_rd_q <= 1'b1;
      else if (wr_end) last_rd_q <= 1'b0;
    end
  end

  assign req_ready = (state_q == ST_RD_DONE) || wr_end || skip_q;
  assign cyc_act   = (state_q == ST_RD_ACCESS) || (state_q == ST_WR_SETUP) ||
                     (state_q == ST_WR_PULSE)  || (state_q == ST_WR_HOLD);
  assign rd_act    = (state_q == ST_RD_ACCESS);
  assign wr_act    = (state_q == ST_WR_PULSE);

  // R5
  we_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_act) |-> ($past(state_q) == ST_WR_SETUP));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R11
  turn_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WR_SETUP) && ($past(state_q) == ST_IDLE)) |-> !$past(last_rd_q));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W           = 17,
  parameter int DATA_W           = 16,
  parameter int CLK_PERIOD_NS    = 8,
  parameter int T_ACCESS_NS      = 55,
  parameter int T_RD_CYCLE_NS    = 55,
  parameter int T_WR_CYCLE_NS    = 55,
  parameter int T_ADDR_TO_END_NS = 45,
  parameter int T_WE_PULSE_NS    = 40,
  parameter int T_DATA_SETUP_NS  = 25,
  parameter int T_ADDR_SETUP_NS  = 0,
  parameter int T_ADDR_HOLD_NS   = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_mask,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_sel_n,
  output logic                   mem_sel,
  output logic                   mem_rd_n,
  output logic                   mem_wr_n,
  output logic [DATA_W/8-1:0]    mem_lane_n,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int N_RD    = imax(1, imax(ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_RD_CYCLE_NS, CLK_PERIOD_NS) - 2));
  localparam int N_SETUP = imax(1, ns_to_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS));
  localparam int N_HOLD  = imax(1, ns_to_cycles(T_ADDR_HOLD_NS, CLK_PERIOD_NS));
  localparam int N_PULSE = imax(
      imax(1, ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS)),
      imax(ns_to_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS),
           imax(ns_to_cycles(T_ADDR_TO_END_NS, CLK_PERIOD_NS) - N_SETUP,
                ns_to_cycles(T_WR_CYCLE_NS, CLK_PERIOD_NS) - N_SETUP - N_HOLD)));
  localparam int N_MAX   = imax(imax(N_RD, N_PULSE), imax(N_SETUP, N_HOLD));
  localparam int CNT_W   = $clog2(N_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_init;
  logic             tmr_expired;
  logic             accept;
  logic             capture;
  logic             cyc_act;
  logic             rd_act;
  logic             wr_act;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .init    (tmr_init),
    .expired (tmr_expired)
  );

  sram_ctl_fsm #(
    .LANES   (LANES),
    .CNT_W   (CNT_W),
    .N_RD    (N_RD),
    .N_SETUP (N_SETUP),
    .N_PULSE (N_PULSE),
    .N_HOLD  (N_HOLD)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_mask    (req_mask),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_init    (tmr_init),
    .accept      (accept),
    .capture     (capture),
    .req_ready   (req_ready),
    .cyc_act     (cyc_act),
    .rd_act      (rd_act),
    .wr_act      (wr_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      mask_q <= req_mask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_io #(.W(8)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .capture   (capture),
      .lane_sel  (mask_q[g]),
      .wdata_in  (req_wdata[g*8 +: 8]),
      .dq_in     (mem_dq_in[g*8 +: 8]),
      .dq_out    (mem_dq_out[g*8 +: 8]),
      .rdata_out (rsp_rdata[g*8 +: 8])
    );
  end

  assign mem_addr   = addr_q;
  assign mem_sel_n  = !cyc_act;
  assign mem_sel    = cyc_act;
  assign mem_rd_n   = !rd_act;
  assign mem_wr_n   = !wr_act;
  assign mem_lane_n = ~(mask_q & {LANES{cyc_act}});
  assign mem_dq_oe  = wr_act;

  // R2
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_lane_n));

  // R7
  no_empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_lane_n != '1));

  // R2
  strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_sel_n && mem_sel && $past(!mem_sel_n)));

endmodule

// File: tb/test_sram_async_ctl.sv
`timescale 1ns/1ps
module test_sram_async_ctl;

  localparam int EXP_RD    = (55 + 7) / 8;
  localparam int EXP_PULSE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  int n_chk = 0;
  int n_err = 0;
  int n_req = 0;

  always #4 clk = ~clk;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_lane_n(mem_lane_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model: small array, read data valid only after the access time.
  logic [15:0] ram [256];
  int          rd_age = 0;
  logic        sel_on, rd_on;

  initial for (int i = 0; i < 256; i++) ram[i] = 16'h0000;

  assign sel_on = !mem_sel_n && mem_sel;
  assign rd_on  = sel_on && !mem_rd_n && mem_wr_n;

  always @(posedge clk) begin
    if (rd_on) rd_age <= rd_age + 1;
    else       rd_age <= 0;
    if (sel_on && !mem_wr_n) begin
      for (int l = 0; l < 2; l++)
        if (!mem_lane_n[l])
          ram[mem_addr[7:0]][l*8 +: 8] <= mem_dq_oe ? mem_dq_out[l*8 +: 8] : 8'hEE;
    end
  end

  always_comb begin
    mem_dq_in = 16'hA5A5;
    if (rd_on && rd_age >= EXP_RD - 1) begin
      for (int l = 0; l < 2; l++)
        if (!mem_lane_n[l]) mem_dq_in[l*8 +: 8] = ram[mem_addr[7:0]][l*8 +: 8];
    end
  end

  // Pin monitor, sampled mid-cycle.
  int rd_run = 0, last_rd_len = 0, we_run = 0, last_we_len = 0;
  int act_run = 0, last_setup = 0, sel_cycles = 0, ready_cnt = 0, viol = 0;
  int gap = 0, last_gap = 0;
  bit trk = 0;
  logic prev_wr = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_rd_n) rd_run++;
      else if (rd_run != 0) begin last_rd_len = rd_run; rd_run = 0; end
      if (!mem_wr_n) we_run++;
      else if (we_run != 0) begin last_we_len = we_run; we_run = 0; end
      if (mem_sel_n) act_run = 0;
      else if (mem_wr_n) act_run++;
      else if (prev_wr) last_setup = act_run;
      prev_wr = mem_wr_n;
      if (!mem_sel_n) sel_cycles++;
      if (req_ready) ready_cnt++;
      if ((mem_dq_oe && mem_wr_n) || (mem_dq_oe && !mem_rd_n) ||
          (!mem_wr_n && mem_lane_n == 2'b11) || (!mem_wr_n && mem_sel_n))
        viol++;
      if (!mem_rd_n) begin gap = 0; trk = 1; end
      else if (trk && !mem_wr_n) begin last_gap = gap; trk = 0; end
      else if (trk) gap++;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd, output int lat);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ready && lat < 100);
    rd = rsp_rdata;
    req_valid = 1'b0;
    n_req++;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "pins in reset",
        {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_lane_n, mem_dq_oe, req_ready},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pins after reset",
        {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_lane_n, mem_dq_oe},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0});
  endtask

  task automatic t_full_word();
    logic [15:0] rd; int lat;
    do_req(1'b1, 17'd5, 16'hC3A1, 2'b11, rd, lat);
    chk("R5", "write latency", lat, 7);
    settle();
    chk("R5", "strobe width", last_we_len, EXP_PULSE);
    chk("R5", "setup cycles", last_setup, 1);
    do_req(1'b0, 17'd5, 16'h0000, 2'b11, rd, lat);
    chk("R3", "read data", rd, 16'hC3A1);
    chk("R4", "read latency", lat, EXP_RD + 1);
    settle();
    chk("R4", "read enable width", last_rd_len, EXP_RD);
    do_req(1'b1, 17'h1FF42, 16'h5A0F, 2'b11, rd, lat);
    settle();
    do_req(1'b0, 17'h1FF42, 16'h0000, 2'b11, rd, lat);
    chk("R3", "read data high address", rd, 16'h5A0F);
    settle();
  endtask

  task automatic t_byte_write();
    logic [15:0] rd; int lat;
    do_req(1'b1, 17'd9, 16'h1234, 2'b11, rd, lat);
    do_req(1'b1, 17'd9, 16'hABCD, 2'b01, rd, lat);
    do_req(1'b0, 17'd9, 16'h0000, 2'b11, rd, lat);
    chk("R7", "low lane write", rd, 16'h12CD);
    do_req(1'b1, 17'd9, 16'h7700, 2'b10, rd, lat);
    do_req(1'b0, 17'd9, 16'h0000, 2'b11, rd, lat);
    chk("R7", "high lane write", rd, 16'h77CD);
    settle();
  endtask

  task automatic t_masked_read();
    logic [15:0] rd; int lat;
    do_req(1'b0, 17'd9, 16'h0000, 2'b10, rd, lat);
    chk("R8", "upper-only read", rd, 16'h7700);
    do_req(1'b0, 17'd9, 16'h0000, 2'b01, rd, lat);
    chk("R8", "lower-only read", rd, 16'h00CD);
    settle();
  endtask

  task automatic t_zero_mask();
    logic [15:0] rd; int lat; int s0;
    #1 s0 = sel_cycles;
    do_req(1'b1, 17'd9, 16'hFFFF, 2'b00, rd, lat);
    chk("R10", "zero-mask latency", lat, 1);
    settle();
    chk("R10", "no select activity", sel_cycles, s0);
    do_req(1'b0, 17'd9, 16'h0000, 2'b11, rd, lat);
    chk("R10", "contents kept", rd, 16'h77CD);
    settle();
  endtask

  task automatic t_turnaround();
    logic [15:0] rd; int lat;
    do_req(1'b0, 17'd5, 16'h0000, 2'b11, rd, lat);
    do_req(1'b1, 17'd6, 16'h0F0F, 2'b11, rd, lat);
    settle();
    chk("R11", "read-to-strobe gap", last_gap, 4);
    do_req(1'b0, 17'd6, 16'h0000, 2'b11, rd, lat);
    chk("R6", "data held to strobe end", rd, 16'h0F0F);
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_full_word();
    t_byte_write();
    t_masked_read();
    t_zero_mask();
    t_turnaround();
    chk("R9", "ready pulses per request", ready_cnt, n_req);
    chk("R6", "bus and strobe violations", viol, 0);
    chk("R2", "strobe outside select", viol, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule